// File: doc/BRIEF.md
# Translation Context Control and Fault Status Register Bank

This block is the software-visible register bank for a set of translation contexts inside an I/O address translation unit. Each context owns three 32-bit registers: a control word, a fault status word and a captured fault address. Software programs and reads them through a simple single-cycle register port: a write strobe, an address and write data, with read data driven combinationally from the address.

The translation engine outside this block reports faults through one fault port. A report carries a context index, four error flags, a 3-bit error code, a 2-bit table level and the faulting address. The bank records the first error per context and keeps it until software clears it. Each context also has an interrupt enable, and one shared interrupt line is raised while any enabled context holds an error.

Software requests a TLB invalidation by setting the flush bit in a context's control word. That bit stays set and is presented to the engine as a busy flag until the engine returns a done pulse for that context. The status word is cleared by any write to it, whatever the data, and that clear also zeroes the captured address. Software must therefore read the address before clearing the status.

Top module: `xlat_ctx_regs`

## Requirements
- R1: Context n (0..3) decodes at byte address n*0x40 with control at +0x00, status at +0x20 and fault address at +0x30; every other offset reads 0 and ignores writes, and writes to the fault address register are ignored.
- R2: Control fields are bit 0 translation enable, bit 1 flush, bit 2 interrupt enable, bit 3 remap enable, bits 5:4 table select, bit 16 access-flag enable and bit 17 attribute-remap enable; these read back as written, all other bits read 0, and every control register is 0 after reset.
- R3: A control write with bit 1 set raises that context's flush bit and flush_busy bit; both stay 1 until flush_done for that context is pulsed, and then read 0 from the next cycle. A done pulse for one context leaves the others pending, and a control write with bit 1 at 0 does not cancel a pending flush.
- R4: A fault report with flt_valid high and nonzero flt_flags ({multi-hit, walk abort, page fault, translation fault} on bits 3..0) sets status bit 4, bit 2, bit 1 and bit 0 from those flags, bits 10:8 from flt_code (1 format error, 4 permission error, 5 secure access error, passed as given) and bits 13:12 from flt_level, and loads flt_addr into the fault address register, all visible in the cycle after the report.
- R5: Any write to a status register, whatever its data, clears all of that context's status bits and sets its fault address register to 0.
- R6: While a context's status holds any of bits 0, 1, 2 or 4, further fault reports to it change neither status nor address; a report with flt_flags equal to 0 is ignored.
- R7: irq is high exactly while some context has interrupt enable set and any of status bits 0, 1, 2 or 4 set.
- R8: When a status write and a fault report for the same context fall in the same cycle, the clear is applied first and the new fault is recorded.
- R9: Writing 0 to a control register clears its enable and field bits; only a pending flush bit remains until its done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| flt_valid | input | 1 | Fault report valid |
| flt_ctx | input | 2 | Context index of the fault report |
| flt_flags | input | 4 | {multi-hit, walk abort, page fault, translation fault} |
| flt_code | input | 3 | Error code of the report |
| flt_level | input | 2 | Table level of the report |
| flt_addr | input | 32 | Faulting address |
| flush_done | input | 4 | Per-context invalidation complete pulse |
| flush_busy | output | 4 | Per-context pending flush request |
| irq | output | 1 | Shared interrupt request |

## Verification
A wrong sticky or capture state shows one cycle after a fault report, as a status word or address that differs when read back, and as an irq level that disagrees with the enable and flags just programmed. A flush bit that clears too early or never clears shows on flush_busy and on the control read in the cycle after the done pulse or write. Clear ordering is exposed by driving a clear and a fault into the same context in one cycle and reading the status at once. Ignored writes are proven by reading back the exact location they could have changed.

// File: rtl/xlat_ctx_pkg.sv
package xlat_ctx_pkg;
   localparam int REG_W = 32;

   // Byte offsets inside one context window
   localparam int OFS_CTRL  = 'h00;
   localparam int OFS_STAT  = 'h20;
   localparam int OFS_FADDR = 'h30;

   // Control word bit positions
   localparam int CB_XLAT  = 0;
   localparam int CB_FLUSH = 1;
   localparam int CB_IRQEN = 2;
   localparam int CB_TREN  = 3;
   localparam int CB_TSEL  = 4;
   localparam int CB_AFEN  = 16;
   localparam int CB_TRE   = 17;

   // Status word bit positions
   localparam int SB_TF   = 0;
   localparam int SB_PF   = 1;
   localparam int SB_ABT  = 2;
   localparam int SB_MHIT = 4;
   localparam int SB_CODE = 8;
   localparam int SB_LVL  = 12;

   localparam int CODE_W  = 3;
   localparam int LVL_W   = 2;
   localparam int FLAG_W  = 4;
endpackage

// File: rtl/xlat_ctx_bank.sv
module xlat_ctx_bank
   import xlat_ctx_pkg::*;
#(
   parameter int VA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic              stat_we,
   input  logic [REG_W-1:0]  wdata,
   input  logic              flt_hit,
   input  logic [FLAG_W-1:0] flt_flags,
   input  logic [CODE_W-1:0] flt_code,
   input  logic [LVL_W-1:0]  flt_level,
   input  logic [VA_W-1:0]   flt_addr,
   input  logic              flush_done,
   output logic [REG_W-1:0]  ctrl_rd,
   output logic [REG_W-1:0]  stat_rd,
   output logic [REG_W-1:0]  faddr_rd,
   output logic              flush_pend,
   output logic              ctx_irq
);
   logic              xlat_q, irqen_q, tren_q, afen_q, tre_q, flush_q;
   logic [1:0]        tsel_q;
   logic [FLAG_W-1:0] flags_q;
   logic [CODE_W-1:0] code_q;
   logic [LVL_W-1:0]  lvl_q;
   logic [VA_W-1:0]   faddr_q;
   logic              has_err, flt_take;
   logic              unused_wbits;

   assign unused_wbits = ^{wdata[REG_W-1:CB_TRE+1], wdata[CB_AFEN-1:CB_TSEL+2]};

   assign has_err  = |flags_q;
   // a clear in the same cycle empties the slot first, so the report lands
   assign flt_take = flt_hit && (|flt_flags) && (!has_err || stat_we);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xlat_q  <= 1'b0;
         irqen_q <= 1'b0;
         tren_q  <= 1'b0;
         afen_q  <= 1'b0;
         tre_q   <= 1'b0;
         tsel_q  <= '0;
      end else if (ctrl_we) begin
         xlat_q  <= wdata[CB_XLAT];
         irqen_q <= wdata[CB_IRQEN];
         tren_q  <= wdata[CB_TREN];
         afen_q  <= wdata[CB_AFEN];
         tre_q   <= wdata[CB_TRE];
         tsel_q  <= wdata[CB_TSEL +: 2];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                        flush_q <= 1'b0;
      else if (ctrl_we && wdata[CB_FLUSH]) flush_q <= 1'b1;
      else if (flush_done)               flush_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q <= '0;
         code_q  <= '0;
         lvl_q   <= '0;
         faddr_q <= '0;
      end else if (flt_take) begin
         flags_q <= flt_flags;
         code_q  <= flt_code;
         lvl_q   <= flt_level;
         faddr_q <= flt_addr;
      end else if (stat_we) begin
         flags_q <= '0;
         code_q  <= '0;
         lvl_q   <= '0;
         faddr_q <= '0;
      end
   end

   always_comb begin
      ctrl_rd             = '0;
      ctrl_rd[CB_XLAT]    = xlat_q;
      ctrl_rd[CB_FLUSH]   = flush_q;
      ctrl_rd[CB_IRQEN]   = irqen_q;
      ctrl_rd[CB_TREN]    = tren_q;
      ctrl_rd[CB_TSEL+:2] = tsel_q;
      ctrl_rd[CB_AFEN]    = afen_q;
      ctrl_rd[CB_TRE]     = tre_q;
   end

   always_comb begin
      stat_rd                  = '0;
      stat_rd[SB_TF]           = flags_q[0];
      stat_rd[SB_PF]           = flags_q[1];
      stat_rd[SB_ABT]          = flags_q[2];
      stat_rd[SB_MHIT]         = flags_q[3];
      stat_rd[SB_CODE+:CODE_W] = code_q;
      stat_rd[SB_LVL+:LVL_W]   = lvl_q;
   end

   assign faddr_rd   = REG_W'(faddr_q);
   assign flush_pend = flush_q;
   assign ctx_irq    = irqen_q & has_err;

   assert_flush_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      flush_q && !flush_done |=> flush_q);
   assert_flush_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
      flush_q && flush_done && !(ctrl_we && wdata[CB_FLUSH]) |=> !flush_q);
   assert_clear_wipes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      stat_we && !(flt_hit && |flt_flags) |=> (flags_q == '0) && (faddr_q == '0));
   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      has_err && !stat_we |=> $stable(faddr_q) && $stable(code_q) && $stable(flags_q));
   assert_irq_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irqen_q && !ctrl_we && flt_hit && (|flt_flags) |=> ctx_irq);
   assert_clear_then_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stat_we && flt_hit && (|flt_flags) |=> has_err);
endmodule

// File: rtl/xlat_ctx_rdmux.sv
module xlat_ctx_rdmux
   import xlat_ctx_pkg::*;
#(
   parameter int NUM_CTX = 4,
   parameter int CTX_LG2 = 6,
   parameter int CTX_IW  = 2
) (
   input  logic [NUM_CTX-1:0][REG_W-1:0] ctrl_v,
   input  logic [NUM_CTX-1:0][REG_W-1:0] stat_v,
   input  logic [NUM_CTX-1:0][REG_W-1:0] faddr_v,
   input  logic [NUM_CTX-1:0]            irq_v,
   input  logic [CTX_IW-1:0]             ctx_sel,
   input  logic [CTX_LG2-1:0]            ofs,
   input  logic                          in_range,
   output logic [REG_W-1:0]              rdata,
   output logic                          irq
);
   always_comb begin
      rdata = '0;
      if (in_range) begin
         if (ofs == CTX_LG2'(OFS_CTRL))       rdata = ctrl_v[ctx_sel];
         else if (ofs == CTX_LG2'(OFS_STAT))  rdata = stat_v[ctx_sel];
         else if (ofs == CTX_LG2'(OFS_FADDR)) rdata = faddr_v[ctx_sel];
      end
   end

   assign irq = |irq_v;
endmodule

// File: rtl/xlat_ctx_regs.sv
module xlat_ctx_regs
   import xlat_ctx_pkg::*;
#(
   parameter int NUM_CTX = 4,
   parameter int CTX_LG2 = 6,
   parameter int ADDR_W  = 8,
   parameter int VA_W    = 32,
   localparam int CTX_IW = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [REG_W-1:0]    reg_wdata,
   output logic [REG_W-1:0]    reg_rdata,
   input  logic                flt_valid,
   input  logic [CTX_IW-1:0]   flt_ctx,
   input  logic [FLAG_W-1:0]   flt_flags,
   input  logic [CODE_W-1:0]   flt_code,
   input  logic [LVL_W-1:0]    flt_level,
   input  logic [VA_W-1:0]     flt_addr,
   input  logic [NUM_CTX-1:0]  flush_done,
   output logic [NUM_CTX-1:0]  flush_busy,
   output logic                irq
);
   localparam int DEC_W = CTX_LG2 + CTX_IW;

   generate
      if (NUM_CTX < 2) begin : g_bad_ctx
         $error("NUM_CTX must be at least 2");
      end
      if (CTX_LG2 < 6) begin : g_bad_lg2
         $error("CTX_LG2 must be at least 6 to hold the fault address offset");
      end
      if (ADDR_W < DEC_W) begin : g_bad_addr
         $error("ADDR_W too small for the context windows");
      end
      if (VA_W > REG_W) begin : g_bad_va
         $error("VA_W must not exceed the register width");
      end
   endgenerate

   logic [CTX_IW-1:0]  ctx_sel;
   logic [CTX_LG2-1:0] ofs;
   logic               hi_zero, in_range;

   assign ctx_sel = reg_addr[CTX_LG2 +: CTX_IW];
   assign ofs     = reg_addr[CTX_LG2-1:0];

   generate
      if (ADDR_W > DEC_W) begin : g_hi
         assign hi_zero = (reg_addr[ADDR_W-1:DEC_W] == '0);
      end else begin : g_nohi
         assign hi_zero = 1'b1;
      end
   endgenerate

   assign in_range = hi_zero && (int'(ctx_sel) < NUM_CTX);

   logic [NUM_CTX-1:0][REG_W-1:0] ctrl_v, stat_v, faddr_v;
   logic [NUM_CTX-1:0]            irq_v;

   for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
      logic sel_i;
      assign sel_i = reg_we && in_range && (int'(ctx_sel) == i);

      xlat_ctx_bank #(.VA_W(VA_W)) u_bank (
         .clk        (clk),
         .rst_n      (rst_n),
         .ctrl_we    (sel_i && (ofs == CTX_LG2'(OFS_CTRL))),
         .stat_we    (sel_i && (ofs == CTX_LG2'(OFS_STAT))),
         .wdata      (reg_wdata),
         .flt_hit    (flt_valid && (int'(flt_ctx) == i)),
         .flt_flags  (flt_flags),
         .flt_code   (flt_code),
         .flt_level  (flt_level),
         .flt_addr   (flt_addr),
         .flush_done (flush_done[i]),
         .ctrl_rd    (ctrl_v[i]),
         .stat_rd    (stat_v[i]),
         .faddr_rd   (faddr_v[i]),
         .flush_pend (flush_busy[i]),
         .ctx_irq    (irq_v[i])
      );
   end

   xlat_ctx_rdmux #(
      .NUM_CTX (NUM_CTX),
      .CTX_LG2 (CTX_LG2),
      .CTX_IW  (CTX_IW)
   ) u_rdmux (
      .ctrl_v   (ctrl_v),
      .stat_v   (stat_v),
      .faddr_v  (faddr_v),
      .irq_v    (irq_v),
      .ctx_sel  (ctx_sel),
      .ofs      (ofs),
      .in_range (in_range),
      .rdata    (reg_rdata),
      .irq      (irq)
   );
endmodule

// File: tb/xlat_ctx_regs_bench.sv
module xlat_ctx_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        flt_valid = 1'b0;
   logic [1:0]  flt_ctx = '0;
   logic [3:0]  flt_flags = '0;
   logic [2:0]  flt_code = '0;
   logic [1:0]  flt_level = '0;
   logic [31:0] flt_addr = '0;
   logic [3:0]  flush_done = '0;
   logic [3:0]  flush_busy;
   logic        irq;

   int tests = 0;
   int fails = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   xlat_ctx_regs u_xlat_ctx_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flt_valid(flt_valid),
      .flt_ctx(flt_ctx), .flt_flags(flt_flags), .flt_code(flt_code),
      .flt_level(flt_level), .flt_addr(flt_addr), .flush_done(flush_done),
      .flush_busy(flush_busy), .irq(irq)
   );

   typedef struct packed {
      logic        wr;
      logic [7:0]  addr;
      logic [31:0] data;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NVEC = 16;
   localparam vec_t VECS [NVEC] = '{
      '{1'b1, 8'h40, 32'hFFFF_FFFD, 32'h0, 4'd2},
      '{1'b0, 8'h40, 32'h0, 32'h0003_003D, 4'd2},     // R2 field readback
      '{1'b1, 8'h80, 32'h0000_0031, 32'h0, 4'd1},
      '{1'b0, 8'h80, 32'h0, 32'h0000_0031, 4'd1},     // R1 ctx2 window
      '{1'b0, 8'hC0, 32'h0, 32'h0, 4'd1},             // R1 ctx3 untouched
      '{1'b0, 8'h00, 32'h0, 32'h0, 4'd1},             // R1 ctx0 untouched
      '{1'b1, 8'h44, 32'h1234_5678, 32'h0, 4'd1},
      '{1'b0, 8'h44, 32'h0, 32'h0, 4'd1},             // R1 unmapped offset
      '{1'b1, 8'h70, 32'h0000_AAAA, 32'h0, 4'd1},
      '{1'b0, 8'h70, 32'h0, 32'h0, 4'd1},             // R1 fault address not writable
      '{1'b1, 8'h40, 32'h0, 32'h0, 4'd9},
      '{1'b0, 8'h40, 32'h0, 32'h0, 4'd9},             // R9 zero write disables
      '{1'b1, 8'hE0, 32'h0000_0055, 32'h0, 4'd5},
      '{1'b0, 8'hE0, 32'h0, 32'h0, 4'd5},             // R5 clear of empty status
      '{1'b1, 8'h80, 32'h0, 32'h0, 4'd9},
      '{1'b0, 8'h80, 32'h0, 32'h0, 4'd9}              // R9 ctx2 cleared
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string req);
      reg_addr = a;
      #1;
      check(reg_rdata === e, req, reg_rdata, e);
   endtask

   task automatic fault(input logic [1:0] c, input logic [3:0] f, input logic [2:0] code,
                        input logic [1:0] lvl, input logic [31:0] a);
      @(negedge clk);
      flt_valid = 1'b1; flt_ctx = c; flt_flags = f; flt_code = code;
      flt_level = lvl; flt_addr = a;
      @(negedge clk);
      flt_valid = 1'b0;
   endtask

   task automatic done_pulse(input logic [3:0] m);
      @(negedge clk);
      flush_done = m;
      @(negedge clk);
      flush_done = '0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 reset state
      rd_chk(8'h00, 32'h0, "R2 reset ctrl0");
      rd_chk(8'hC0, 32'h0, "R2 reset ctrl3");
      rd_chk(8'h20, 32'h0, "R4 reset status0");
      check(irq === 1'b0, "R7 reset irq", 32'(irq), 32'h0);
      check(flush_busy === 4'h0, "R3 reset busy", 32'(flush_busy), 32'h0);

      for (int i = 0; i < NVEC; i++) begin
         if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
         else rd_chk(VECS[i].addr, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
      end

      // R3 flush lifetime
      wr(8'h00, 32'h0000_0002);
      wr(8'h40, 32'h0000_0002);
      rd_chk(8'h00, 32'h0000_0002, "R3 flush reads 1");
      check(flush_busy === 4'b0011, "R3 busy set", 32'(flush_busy), 32'h3);
      wr(8'h00, 32'h0);
      rd_chk(8'h00, 32'h0000_0002, "R9 zero write keeps pending flush");
      done_pulse(4'b0010);
      check(flush_busy === 4'b0001, "R3 done only clears its context", 32'(flush_busy), 32'h1);
      rd_chk(8'h00, 32'h0000_0002, "R3 ctx0 still pending");
      done_pulse(4'b0001);
      rd_chk(8'h00, 32'h0, "R3 flush self-clears");

      // R4 capture, R7 irq gating
      fault(2'd2, 4'b0001, 3'd4, 2'd2, 32'hDEAD_BEEF);
      rd_chk(8'hA0, 32'h0000_2401, "R4 status translation fault");
      rd_chk(8'hB0, 32'hDEAD_BEEF, "R4 fault address");
      check(irq === 1'b0, "R7 irq masked", 32'(irq), 32'h0);
      wr(8'h80, 32'h0000_0004);
      check(irq === 1'b1, "R7 irq enabled", 32'(irq), 32'h1);

      // R6 sticky
      fault(2'd2, 4'b0010, 3'd5, 2'd1, 32'h0000_1234);
      rd_chk(8'hA0, 32'h0000_2401, "R6 status unchanged");
      rd_chk(8'hB0, 32'hDEAD_BEEF, "R6 address unchanged");

      // R5 clear with arbitrary data
      wr(8'hA0, 32'hFFFF_FFFF);
      rd_chk(8'hA0, 32'h0, "R5 status cleared");
      rd_chk(8'hB0, 32'h0, "R5 address cleared");
      check(irq === 1'b0, "R7 irq drops after clear", 32'(irq), 32'h0);

      // R6 zero-flag report ignored
      fault(2'd1, 4'b0000, 3'd4, 2'd3, 32'h5555_0000);
      rd_chk(8'h60, 32'h0, "R6 zero-flag status");
      rd_chk(8'h70, 32'h0, "R6 zero-flag address");

      // R4 multi-hit mapping
      fault(2'd0, 4'b1000, 3'd1, 2'd1, 32'h0000_0F00);
      rd_chk(8'h20, 32'h0000_1110, "R4 multi-hit bit 4");

      // R8 clear and fault in the same cycle
      fault(2'd3, 4'b0100, 3'd0, 2'd3, 32'h0000_1111);
      rd_chk(8'hE0, 32'h0000_3004, "R4 walk abort");
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 8'hE0; reg_wdata = 32'h0;
      flt_valid = 1'b1; flt_ctx = 2'd3; flt_flags = 4'b0010; flt_code = 3'd4;
      flt_level = 2'd1; flt_addr = 32'h0000_2222;
      @(negedge clk);
      reg_we = 1'b0; flt_valid = 1'b0;
      rd_chk(8'hE0, 32'h0000_1402, "R8 new fault after clear");
      rd_chk(8'hF0, 32'h0000_2222, "R8 new address after clear");

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule